// File: doc/BRIEF.md
# Inbound Snoop Response Sequencer

This block runs the cache-side response to a snoop raised when a PCI master reads or writes main memory. It is given the kind of access, the first-level tag result (miss, clean hit or dirty hit) and the second-level tag result (hit and dirty). It is also told whether the CPU already has a read to PCI under way. From these inputs it picks one of four responses: a write-back from the first-level cache through the CPU bus, a write-back from the second-level cache into the data buffers, an invalidation only, or no action.

For a dirty first-level line the sequencer holds the CPU address bus. If a CPU read to PCI is pending, it aborts that read so the write-back runs first. It then hands the address lines back to the CPU and paces the four-beat burst with a ready strobe. While the burst runs it tells the data buffers where each quadword goes. After a read snoop the data goes to both PCI and memory. After a write snoop it goes only to the memory posted-write buffer. Write snoops end with a one-cycle invalidate of whichever cache levels hold the line. Read snoops never invalidate. Only one snoop runs at a time.

Top module: `snoop_seq`

## Requirements
- R1: Out of reset and whenever idle, `busy`, `cpuHold`, `cpuBackoff`, `burstRdy`, `l2WbReq`, `l1InvReq` and `l2InvReq` are low and `bufCmd` is 5'h00 (no-op). A snoop needing no action (a read without a dirty line, or a write that hits nowhere) leaves `busy` low.
- R2: On a dirty first-level hit (`l1Result` = 2'd2), the first busy cycle drives the address-setup command: 5'h11 for a read snoop, 5'h12 for a write snoop. The next cycle drives 5'h00 so the buffers let go of the address lines.
- R3: When `cpuAds` is high in cycle c, `burstRdy` is high in cycles c+3 through c+6 and low in between.
- R4: For a read snoop, the four burst beats carry `bufCmd` 5'h05 (first quadword to PCI and memory) and then 5'h06 (next quadword to PCI and memory) three times.
- R5: For a write snoop with a dirty first-level hit, all four burst beats carry `bufCmd` 5'h09 (quadword to memory only).
- R6: `cpuHold` is high from the first busy cycle of a dirty first-level response through the last burst beat, and low in the cycle after it.
- R7: `cpuBackoff` is high for exactly the first busy cycle of a dirty first-level response when `cpuReadPci` was high at accept, and is otherwise never high.
- R8: When the first level is not dirty and the second level hits dirty (`l2Hit` = `l2Dirty` = 1), `l2WbReq` is high and `bufCmd` is 5'h14 from the first busy cycle until the cycle after `l2WbDone` is sampled high.
- R9: Every write snoop that found the line in either level ends with one busy cycle in which `l2InvReq` equals the second-level hit and `l1InvReq` equals the first-level hit. The block is idle in the next cycle.
- R10: A read snoop never raises `l1InvReq` or `l2InvReq`.
- R11: A write snoop that hits a clean second-level line with a first-level miss or clean hit transfers no data: its only busy cycle is the invalidate cycle.
- R12: A dirty first-level write-back never raises `l2WbReq`, even when the second level missed.
- R13: `snoopValid` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| snoopValid | input | 1 | Snoop request, taken when idle |
| snoopIsWrite | input | 1 | 1 = PCI master write, 0 = read |
| l1Result | input | 2 | First-level result: 0 miss, 1 clean hit, 2 dirty hit |
| l2Hit | input | 1 | Second-level tag hit |
| l2Dirty | input | 1 | Second-level line modified |
| cpuReadPci | input | 1 | A CPU read to PCI has started |
| cpuAds | input | 1 | CPU address strobe opening the write-back |
| l2WbDone | input | 1 | Second-level write-back handshake complete |
| busy | output | 1 | Snoop in progress |
| cpuHold | output | 1 | CPU address hold |
| cpuBackoff | output | 1 | CPU backoff (abort) |
| burstRdy | output | 1 | Burst-ready strobe to the CPU |
| l2WbReq | output | 1 | Second-level write-back request |
| l2InvReq | output | 1 | Second-level invalidate |
| l1InvReq | output | 1 | First-level invalidate |
| bufCmd | output | 5 | Data buffer command |

## Verification
The bench builds the block with its default parameters: a lead of three clocks from the address strobe to the first beat, and four beats. This exposes the exact 3-1-1-1 pacing, the first-beat command against the following-beat commands, and the hand-off from the last beat to the invalidate cycle. Varying the delay before the address strobe and before the second-level handshake shows that the wait states stretch without shifting the beats. A snoop offered in the middle of a response shows that requests are ignored while busy.

// File: rtl/snoop_seq_pkg.sv
package snoop_seq_pkg;

  localparam int CMD_W = 5;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP        = 5'h00,
    CMD_POST_FIRST = 5'h05,
    CMD_POST_NEXT  = 5'h06,
    CMD_POST_MEM   = 5'h09,
    CMD_SETUP_RD   = 5'h11,
    CMD_SETUP_WR   = 5'h12,
    CMD_L2_DRAIN   = 5'h14
  } bufCmdE;

  typedef enum logic [1:0] {
    L1_MISS  = 2'd0,
    L1_CLEAN = 2'd1,
    L1_DIRTY = 2'd2
  } l1ResultE;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadSnoop;
    logic loadLat;
    logic loadBeat;
    logic decCnt;
    logic cmdSetup;
    logic cmdBeat;
    logic cmdL2Wb;
    logic doInv;
  } ctrlStrobeT;

  // Status from the datapath back to the control FSM
  typedef struct packed {
    logic capWrite;
    logic capPend;
    logic cntZero;
  } dpFlagsT;

endpackage

// File: rtl/snoop_seq_dp.sv
module snoop_seq_dp
  import snoop_seq_pkg::*;
#(
  parameter int FIRST_LAT = 3,
  parameter int BEATS     = 4,
  parameter int CNT_W     = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strobe,
  input  logic             snoopIsWrite,
  input  logic [1:0]       l1Result,
  input  logic             l2Hit,
  input  logic             cpuReadPci,
  output dpFlagsT          flags,
  output logic [CMD_W-1:0] bufCmd,
  output logic             l1InvReq,
  output logic             l2InvReq
);

  localparam logic [CNT_W-1:0] LEAD_LOAD = CNT_W'(FIRST_LAT - 2);
  localparam logic [CNT_W-1:0] BEAT_LOAD = CNT_W'(BEATS - 1);

  logic             capWrite;
  logic             capL1Hit;
  logic             capL2Hit;
  logic             capPend;
  logic [CNT_W-1:0] cnt;

  // Snoop attributes captured at accept
  always_ff @(posedge clk) begin
    if (!rstN) begin
      capWrite <= 1'b0;
      capL1Hit <= 1'b0;
      capL2Hit <= 1'b0;
      capPend  <= 1'b0;
    end else if (strobe.loadSnoop) begin
      capWrite <= snoopIsWrite;
      capL1Hit <= (l1Result != L1_MISS);
      capL2Hit <= l2Hit;
      capPend  <= cpuReadPci;
    end
  end

  // Shared counter: lead-in wait, then beat count
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strobe.loadLat) begin
      cnt <= LEAD_LOAD;
    end else if (strobe.loadBeat) begin
      cnt <= BEAT_LOAD;
    end else if (strobe.decCnt && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign flags.capWrite = capWrite;
  assign flags.capPend  = capPend;
  assign flags.cntZero  = (cnt == '0);

  always_comb begin
    bufCmd = CMD_NOP;
    if (strobe.cmdSetup) begin
      bufCmd = capWrite ? CMD_SETUP_WR : CMD_SETUP_RD;
    end else if (strobe.cmdBeat) begin
      if (capWrite)              bufCmd = CMD_POST_MEM;
      else if (cnt == BEAT_LOAD) bufCmd = CMD_POST_FIRST;
      else                       bufCmd = CMD_POST_NEXT;
    end else if (strobe.cmdL2Wb) begin
      bufCmd = CMD_L2_DRAIN;
    end
  end

  assign l1InvReq = strobe.doInv & capL1Hit;
  assign l2InvReq = strobe.doInv & capL2Hit;

  AST_INV_WRITE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (l1InvReq || l2InvReq) |-> capWrite); // R10

  AST_L2INV_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    l2InvReq |=> !l2InvReq); // R9

  AST_BEAT_NOT_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdBeat |-> (bufCmd != CMD_SETUP_RD && bufCmd != CMD_SETUP_WR)); // R4

endmodule

// File: rtl/snoop_seq_ctrl.sv
module snoop_seq_ctrl
  import snoop_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       snoopValid,
  input  logic       snoopIsWrite,
  input  logic [1:0] l1Result,
  input  logic       l2Hit,
  input  logic       l2Dirty,
  input  logic       cpuAds,
  input  logic       l2WbDone,
  input  dpFlagsT    flags,
  output ctrlStrobeT strobe,
  output logic       busy,
  output logic       cpuHold,
  output logic       cpuBackoff,
  output logic       burstRdy,
  output logic       l2WbReq
);

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_RELEASE, ST_LEAD, ST_BEAT, ST_L2WB, ST_INV
  } stateE;

  stateE state, nxt;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nxt;
  end

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_IDLE: begin
        if (snoopValid) begin
          strobe.loadSnoop = 1'b1;
          if (l1Result == L1_DIRTY)
            nxt = ST_SETUP;
          else if (l2Hit && l2Dirty)
            nxt = ST_L2WB;
          else if (snoopIsWrite && (l2Hit || l1Result == L1_CLEAN))
            nxt = ST_INV;
        end
      end
      ST_SETUP: begin
        strobe.cmdSetup = 1'b1;
        nxt = ST_RELEASE;
      end
      ST_RELEASE: begin
        if (cpuAds) begin
          strobe.loadLat = 1'b1;
          nxt = ST_LEAD;
        end
      end
      ST_LEAD: begin
        if (flags.cntZero) begin
          strobe.loadBeat = 1'b1;
          nxt = ST_BEAT;
        end else begin
          strobe.decCnt = 1'b1;
        end
      end
      ST_BEAT: begin
        strobe.cmdBeat = 1'b1;
        if (flags.cntZero) nxt = flags.capWrite ? ST_INV : ST_IDLE;
        else               strobe.decCnt = 1'b1;
      end
      ST_L2WB: begin
        strobe.cmdL2Wb = 1'b1;
        if (l2WbDone) nxt = flags.capWrite ? ST_INV : ST_IDLE;
      end
      ST_INV: begin
        strobe.doInv = 1'b1;
        nxt = ST_IDLE;
      end
      default: nxt = ST_IDLE;
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign cpuHold    = (state == ST_SETUP) || (state == ST_RELEASE) ||
                      (state == ST_LEAD)  || (state == ST_BEAT);
  assign cpuBackoff = (state == ST_SETUP) && flags.capPend;
  assign burstRdy   = (state == ST_BEAT);
  assign l2WbReq    = (state == ST_L2WB);

  AST_BACKOFF_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    cpuBackoff |=> !cpuBackoff); // R7

  AST_BRDY_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    burstRdy |-> cpuHold); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!cpuHold && !burstRdy && !l2WbReq && !cpuBackoff)); // R1

  AST_NO_L2WB_IN_L1WB: assert property (@(posedge clk) disable iff (!rstN)
    cpuHold |-> !l2WbReq); // R12

  AST_LEAD_TO_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RELEASE && cpuAds) |=> !burstRdy); // R3

endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
  import snoop_seq_pkg::*;
#(
  parameter int FIRST_LAT = 3,
  parameter int BEATS     = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       snoopValid,
  input  logic       snoopIsWrite,
  input  logic [1:0] l1Result,
  input  logic       l2Hit,
  input  logic       l2Dirty,
  input  logic       cpuReadPci,
  input  logic       cpuAds,
  input  logic       l2WbDone,
  output logic       busy,
  output logic       cpuHold,
  output logic       cpuBackoff,
  output logic       burstRdy,
  output logic       l2WbReq,
  output logic       l2InvReq,
  output logic       l1InvReq,
  output logic [4:0] bufCmd
);

  // FIRST_LAT must be at least 2 (one release cycle plus lead-in)
  localparam int CNT_MAX = (FIRST_LAT > BEATS) ? FIRST_LAT : BEATS;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  ctrlStrobeT strobe;
  dpFlagsT    flags;

  snoop_seq_ctrl uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .snoopValid   (snoopValid),
    .snoopIsWrite (snoopIsWrite),
    .l1Result     (l1Result),
    .l2Hit        (l2Hit),
    .l2Dirty      (l2Dirty),
    .cpuAds       (cpuAds),
    .l2WbDone     (l2WbDone),
    .flags        (flags),
    .strobe       (strobe),
    .busy         (busy),
    .cpuHold      (cpuHold),
    .cpuBackoff   (cpuBackoff),
    .burstRdy     (burstRdy),
    .l2WbReq      (l2WbReq)
  );

  snoop_seq_dp #(
    .FIRST_LAT (FIRST_LAT),
    .BEATS     (BEATS),
    .CNT_W     (CNT_W)
  ) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .snoopIsWrite (snoopIsWrite),
    .l1Result     (l1Result),
    .l2Hit        (l2Hit),
    .cpuReadPci   (cpuReadPci),
    .flags        (flags),
    .bufCmd       (bufCmd),
    .l1InvReq     (l1InvReq),
    .l2InvReq     (l2InvReq)
  );

endmodule

// File: tb/snoop_seq_test.sv
module snoop_seq_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       snoopValid = 1'b0, snoopIsWrite = 1'b0;
  logic [1:0] l1Result = 2'd0;
  logic       l2Hit = 1'b0, l2Dirty = 1'b0, cpuReadPci = 1'b0;
  logic       cpuAds = 1'b0, l2WbDone = 1'b0;
  logic       busy, cpuHold, cpuBackoff, burstRdy, l2WbReq, l2InvReq, l1InvReq;
  logic [4:0] bufCmd;

  always #4 clk = ~clk; // 125 MHz

  snoop_seq uut (
    .clk(clk), .rstN(rstN), .snoopValid(snoopValid), .snoopIsWrite(snoopIsWrite),
    .l1Result(l1Result), .l2Hit(l2Hit), .l2Dirty(l2Dirty), .cpuReadPci(cpuReadPci),
    .cpuAds(cpuAds), .l2WbDone(l2WbDone), .busy(busy), .cpuHold(cpuHold),
    .cpuBackoff(cpuBackoff), .burstRdy(burstRdy), .l2WbReq(l2WbReq),
    .l2InvReq(l2InvReq), .l1InvReq(l1InvReq), .bufCmd(bufCmd)
  );

  typedef struct {
    logic [11:0] exp;
    string       tag;
  } itemT;

  itemT expQ[$];
  int   checks = 0;
  int   fails  = 0;
  int   cycleNo = 0;
  bit   finished = 0;

  localparam logic [11:0] IDLE = 12'h000;

  function automatic logic [11:0] mk(input logic b, h, bo, br, wb, i2, i1, input logic [4:0] c);
    return {b, h, bo, br, wb, i2, i1, c};
  endfunction

  // Monitor: pops one expectation per cycle, shortly after the clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      cycleNo++;
      if (expQ.size() > 0) begin
        itemT it;
        logic [11:0] act;
        it  = expQ.pop_front();
        act = {busy, cpuHold, cpuBackoff, burstRdy, l2WbReq, l2InvReq, l1InvReq, bufCmd};
        checks++;
        if (act !== it.exp) begin
          fails++;
          $display("FAIL %s cycle %0d: actual %h expected %h", it.tag, cycleNo, act, it.exp);
        end
      end
    end
  end

  // Driver: set inputs for the next edge, push the outputs that edge must produce
  task automatic step(input logic v, w, input logic [1:0] l1, input logic h, d, p, a, wd,
                      input logic [11:0] e, input string tag);
    @(negedge clk);
    snoopValid = v; snoopIsWrite = w; l1Result = l1; l2Hit = h; l2Dirty = d;
    cpuReadPci = p; cpuAds = a; l2WbDone = wd;
    expQ.push_back('{e, tag});
  endtask

  task automatic quiet(input logic [11:0] e, input string tag);
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, e, tag);
  endtask

  // Dirty first-level write-back through the CPU bus
  task automatic dirtyL1(input logic w, h, p, input int adsGap, input bit poke);
    logic [11:0] rel;
    rel = mk(1, 1, 0, 0, 0, 0, 0, 5'h00);
    step(1'b1, w, 2'd2, h, 1'b0, p, 1'b0, 1'b0,
         mk(1, 1, p, 0, 0, 0, 0, w ? 5'h12 : 5'h11), p ? "R7" : "R2");
    quiet(rel, "R2");
    for (int i = 0; i < adsGap; i++) begin
      if (poke && i == 0)
        step(1'b1, 1'b1, 2'd1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, rel, "R13");
      else
        quiet(rel, "R6");
    end
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, rel, "R3");
    quiet(rel, "R3");
    for (int i = 0; i < 4; i++) begin
      quiet(mk(1, 1, 0, 1, 0, 0, 0, w ? 5'h09 : (i == 0 ? 5'h05 : 5'h06)),
            w ? "R5" : (i == 0 ? "R4" : "R12"));
    end
    if (w) quiet(mk(1, 0, 0, 0, 0, h, 1, 5'h00), "R9");
    quiet(IDLE, "R6");
  endtask

  // Dirty second-level write-back into the buffers
  task automatic l2Drain(input logic w, input logic [1:0] l1, input int wait_n);
    logic [11:0] wb;
    wb = mk(1, 0, 0, 0, 1, 0, 0, 5'h14);
    step(1'b1, w, l1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, wb, "R8");
    for (int i = 0; i < wait_n; i++) quiet(wb, "R8");
    step(1'b0, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
         w ? mk(1, 0, 0, 0, 0, 1, l1 != 2'd0, 5'h00) : IDLE, w ? "R9" : "R10");
    if (w) quiet(IDLE, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    quiet(IDLE, "R1");
    quiet(IDLE, "R1");

    dirtyL1(1'b0, 1'b0, 1'b0, 0, 1'b0);   // read snoop, fast ADS
    dirtyL1(1'b0, 1'b1, 1'b1, 3, 1'b1);   // read, pending CPU read, late ADS, poke
    dirtyL1(1'b1, 1'b1, 1'b0, 1, 1'b0);   // write, L2 hit invalidated too
    dirtyL1(1'b1, 1'b0, 1'b1, 2, 1'b0);   // write, L2 miss, backoff

    l2Drain(1'b0, 2'd0, 0);
    l2Drain(1'b0, 2'd1, 3);
    l2Drain(1'b1, 2'd0, 2);
    l2Drain(1'b1, 2'd1, 0);

    // Write hitting clean L2 line: invalidate only
    step(1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, mk(1, 0, 0, 0, 0, 1, 0, 5'h00), "R11");
    quiet(IDLE, "R11");
    step(1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, mk(1, 0, 0, 0, 0, 1, 1, 5'h00), "R11");
    quiet(IDLE, "R11");
    // Write with clean L1 hit, L2 miss
    step(1'b1, 1'b1, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, mk(1, 0, 0, 0, 0, 0, 1, 5'h00), "R9");
    quiet(IDLE, "R9");
    // Read hitting clean lines: nothing happens
    step(1'b1, 1'b0, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, IDLE, "R10");
    quiet(IDLE, "R10");
    // Write missing everywhere: nothing happens
    step(1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, IDLE, "R1");
    quiet(IDLE, "R1");
    quiet(IDLE, "R1");

    wait (expQ.size() == 0);
    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule